// File: doc/BRIEF.md
# Flash Program Controller Register Block

This block is the software-facing front end of an embedded flash programming engine. A 32-bit register bus reaches four registers by byte offset: an unlock-key register, an option-key register, a status register and a control register. A second address space, the flash window, is selected by a separate input. A halfword written into that window while programming is enabled starts a single program operation on an external flash array port.

Before it writes anything, the block reads the target halfword through the array port. If the cell is not blank (0xFFFF), the operation stops with a programming error and no program strobe is issued. If the cell is blank, the block pulses the program strobe and waits for the array's done pulse. It then raises an end-of-operation flag.

Two 32-bit key values must be written in order to open the control register, and the same two values enable option-byte writing. All error and completion flags are cleared by writing 1 to them. One interrupt output combines the flags, each gated by its enable bit. Writing 1 to the reload bit produces a one-cycle reload request and a matching system-reset request.

Top module: `flash_prog_ctl`

## Requirements
- R1: After reset, the control register (offset 0x10) reads 0x0000_0080, so the lock bit 7 is set. The status register (offset 0x0C) reads 0, and `irq`, `obl_req` and `sys_rst_req` are low.
- R2: Writing 0x45670123 and then 0xCDEF89AB to offset 0x04 while locked clears lock bit 7. Any other value written there while locked jams the lock until the next reset, and a later correct sequence has no effect. Writing 1 to bit 7 while unlocked relocks the register.
- R3: While the lock bit is set, control-register writes change nothing.
- R4: The writable control bits are 0, 1, 2, 4, 5, 6, 10 and 12. Reserved bits read 0. Bit 13 (reload) always reads 0. The unused offsets and both key registers read 0.
- R5: Control bit 9 (option write enable) is set only when 0x45670123 and then 0xCDEF89AB are written to offset 0x08 while unlocked. A control write cannot set it, and a control write with bit 9 at 0 clears it.
- R6: A halfword write to the flash window while PG (bit 0) is 1, the lock is clear and the block is idle starts programming. Busy (status bit 0) reads 1 from the cycle after that write until the done pulse. On done, busy drops and end-of-operation (status bit 5) is set.
- R7: If the target halfword does not read 0xFFFF, the error flag (status bit 2) is set, busy drops one cycle after entering the check, no program strobe is issued, and the cell keeps its value.
- R8: A flash-window write that arrives while busy is ignored.
- R9: A flash-window write with PG set while locked programs nothing and sets the write-protect error (status bit 4).
- R10: Status bits 2, 4 and 5 clear only when 1 is written to that bit at offset 0x0C. Writing 0 leaves them set.
- R11: `irq` is high exactly when (bit 12 and status bit 5) or (bit 10 and (status bit 2 or status bit 4)).
- R12: A control write with bit 13 at 1 while unlocked drives `obl_req` and `sys_rst_req` high together for exactly one cycle.
- R13: A flash-window write with PG clear starts nothing and issues no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 1 = flash window, 0 = registers |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| fl_addr | output | AW | Array byte address of the target halfword |
| fl_rdata | input | 16 | Array content at `fl_addr` |
| fl_wdata | output | 16 | Halfword to program |
| fl_prog | output | 1 | One-cycle program strobe |
| fl_done | input | 1 | Array finished programming |
| irq | output | 1 | Combined interrupt |
| obl_req | output | 1 | Option reload request pulse |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
A wrong sequencer state shows up on the busy bit one cycle after the starting write. It also shows up as a program strobe on a non-blank cell, or as a cell in the array model that changed when it should not have. A key tracker in the wrong state shows up in the next control-register read, through the lock bit and the option write enable bit. A flag left set, or cleared too early, shows up at once in the status readback and on `irq`, because both are decoded without delay from the flag registers.

// File: rtl/flash_prog_ctl.sv
module flash_prog_ctl #(
  parameter int AW = 12,
  parameter logic [31:0] KEY_A = 32'h4567_0123,
  parameter logic [31:0] KEY_B = 32'hCDEF_89AB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic          bus_win,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [AW-1:0] fl_addr,
  input  logic [15:0]   fl_rdata,
  output logic [15:0]   fl_wdata,
  output logic          fl_prog,
  input  logic          fl_done,
  output logic          irq,
  output logic          obl_req,
  output logic          sys_rst_req
);
  localparam logic [AW-1:0] OFS_KEY  = AW'(4);
  localparam logic [AW-1:0] OFS_OKEY = AW'(8);
  localparam logic [AW-1:0] OFS_SR   = AW'(12);
  localparam logic [AW-1:0] OFS_CR   = AW'(16);
  localparam logic [31:0]   CR_RW    = 32'h0000_1477;
  localparam logic [15:0]   BLANK    = 16'hFFFF;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_PROG, S_WAIT} st_t;

  st_t         st;
  logic [31:0] cr_q;
  logic        lock, lk_step, lk_dead;
  logic        optwre, ok_step, ok_dead;
  logic        pgerr, wrperr, eop, obl_q;
  logic [AW-1:0] tgt_addr;
  logic [15:0]   tgt_data;

  wire reg_wr  = bus_en & bus_we & ~bus_win;
  wire win_wr  = bus_en & bus_we & bus_win;
  wire cr_wr   = reg_wr & (bus_addr == OFS_CR);
  wire sr_wr   = reg_wr & (bus_addr == OFS_SR);
  wire key_wr  = reg_wr & (bus_addr == OFS_KEY);
  wire okey_wr = reg_wr & (bus_addr == OFS_OKEY);
  wire cr_open = cr_wr & ~lock;
  wire busy    = (st != S_IDLE);
  wire pg      = cr_q[0];
  wire start   = win_wr & pg & ~lock & ~busy;
  wire wp_hit  = win_wr & pg & lock;
  wire blank   = (fl_rdata == BLANK);

  assign fl_addr     = tgt_addr;
  assign fl_wdata    = tgt_data;
  assign fl_prog     = (st == S_PROG);
  assign obl_req     = obl_q;
  assign sys_rst_req = obl_q;
  assign irq = (cr_q[12] & eop) | (cr_q[10] & (pgerr | wrperr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_CHECK;
          tgt_addr <= bus_addr;
          tgt_data <= bus_wdata[15:0];
        end
        S_CHECK: st <= blank ? S_PROG : S_IDLE;
        S_PROG:  st <= S_WAIT;
        default: if (fl_done) st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgerr  <= 1'b0;
      wrperr <= 1'b0;
      eop    <= 1'b0;
    end else begin
      pgerr  <= ((st == S_CHECK) & ~blank) | (pgerr & ~(sr_wr & bus_wdata[2]));
      wrperr <= wp_hit | (wrperr & ~(sr_wr & bus_wdata[4]));
      eop    <= ((st == S_WAIT) & fl_done) | (eop & ~(sr_wr & bus_wdata[5]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock    <= 1'b1;
      lk_step <= 1'b0;
      lk_dead <= 1'b0;
    end else if (cr_open & bus_wdata[7]) begin
      lock    <= 1'b1;
      lk_step <= 1'b0;
    end else if (key_wr & lock & ~lk_dead) begin
      if (!lk_step && bus_wdata == KEY_A) lk_step <= 1'b1;
      else if (lk_step && bus_wdata == KEY_B) begin
        lock    <= 1'b0;
        lk_step <= 1'b0;
      end else lk_dead <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      optwre  <= 1'b0;
      ok_step <= 1'b0;
      ok_dead <= 1'b0;
    end else if (cr_open & ~bus_wdata[9]) begin
      optwre  <= 1'b0;
      ok_step <= 1'b0;
    end else if (okey_wr & ~lock & ~ok_dead) begin
      if (!ok_step && bus_wdata == KEY_A) ok_step <= 1'b1;
      else if (ok_step && bus_wdata == KEY_B) begin
        optwre  <= 1'b1;
        ok_step <= 1'b0;
      end else ok_dead <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q  <= '0;
      obl_q <= 1'b0;
    end else begin
      if (cr_open) cr_q <= bus_wdata & CR_RW;
      obl_q <= cr_open & bus_wdata[13];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CR)
      bus_rdata = cr_q | {22'd0, optwre, 1'b0, lock, 7'd0};
    else if (bus_addr == OFS_SR)
      bus_rdata = {26'd0, eop, wrperr, 1'b0, pgerr, 1'b0, busy};
  end

  a_r7_prog_only_blank: assert property (@(posedge clk) disable iff (!rst_n)
    fl_prog |-> $past(fl_rdata) == BLANK);
  a_r10_pgerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pgerr && !(sr_wr && bus_wdata[2])) |=> pgerr);
  a_r10_eop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && !(sr_wr && bus_wdata[5])) |=> eop);
  a_r6_busy_ends_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (eop || pgerr));
  a_r12_obl_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    obl_req |-> $past(cr_wr && bus_wdata[13]));
  a_r5_optwre_by_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(optwre) |-> $past(okey_wr && bus_wdata == KEY_B));
  a_r8_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && win_wr) |=> ($stable(fl_addr) && $stable(fl_wdata)));
  a_r9_locked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !busy) |=> !busy);
endmodule

// File: tb/flash_prog_ctl_test.sv
module flash_prog_ctl_test;
  localparam int AW = 12;
  localparam logic [31:0] KA = 32'h4567_0123;
  localparam logic [31:0] KB = 32'hCDEF_89AB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 0, bus_we = 0, bus_win = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [AW-1:0] fl_addr;
  logic [15:0] fl_rdata, fl_wdata;
  logic fl_prog, fl_done, irq, obl_req, sys_rst_req;
  int checks = 0, errors = 0, strobes = 0, obl_n = 0, rst_n_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_prog_ctl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_win(bus_win),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fl_addr(fl_addr), .fl_rdata(fl_rdata), .fl_wdata(fl_wdata), .fl_prog(fl_prog),
    .fl_done(fl_done), .irq(irq), .obl_req(obl_req), .sys_rst_req(sys_rst_req));

  logic [15:0] mem [16];
  logic [3:0]  pa;
  logic [15:0] pd;
  int          cnt;
  assign fl_rdata = mem[fl_addr[4:1]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 16'hFFFF;
      mem[5] <= 16'h0000;
      cnt <= 0; fl_done <= 1'b0; pa <= '0; pd <= '0;
    end else begin
      fl_done <= 1'b0;
      if (fl_prog) begin
        pa <= fl_addr[4:1]; pd <= fl_wdata; cnt <= 3; strobes <= strobes + 1;
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin mem[pa] <= pd; fl_done <= 1'b1; end
      end
      if (obl_req) obl_n <= obl_n + 1;
      if (sys_rst_req) rst_n_cnt <= rst_n_cnt + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic win, logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_win = win; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_win = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; bus_win = 0;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); rd(12'h0C, s);
      if (!s[0]) break;
    end
  endtask

  // {req, write, offset, data, expected}
  localparam int NV = 19;
  localparam logic [76:0] VEC [NV] = '{
    {4'd1, 1'b0, 8'h10, 32'h0,        32'h80},    // R1 control reset
    {4'd1, 1'b0, 8'h0C, 32'h0,        32'h0},     // R1 status reset
    {4'd3, 1'b1, 8'h10, 32'h1477,     32'h0},
    {4'd3, 1'b0, 8'h10, 32'h0,        32'h80},    // R3 locked write ignored
    {4'd2, 1'b1, 8'h04, KA,           32'h0},
    {4'd2, 1'b1, 8'h04, KB,           32'h0},
    {4'd2, 1'b0, 8'h10, 32'h0,        32'h0},     // R2 unlocked
    {4'd4, 1'b1, 8'h10, 32'hFFFF_FF7F,32'h0},
    {4'd4, 1'b0, 8'h10, 32'h0,        32'h1477},  // R4 field map
    {4'd5, 1'b1, 8'h10, 32'h200,      32'h0},
    {4'd5, 1'b0, 8'h10, 32'h0,        32'h0},     // R5 no direct set
    {4'd5, 1'b1, 8'h08, KA,           32'h0},
    {4'd5, 1'b1, 8'h08, KB,           32'h0},
    {4'd5, 1'b0, 8'h10, 32'h0,        32'h200},   // R5 key sets
    {4'd5, 1'b1, 8'h10, 32'h0,        32'h0},
    {4'd5, 1'b0, 8'h10, 32'h0,        32'h0},     // R5 clear by 0
    {4'd4, 1'b0, 8'h04, 32'h0,        32'h0},     // R4 key reads 0
    {4'd4, 1'b0, 8'h08, 32'h0,        32'h0},     // R4 key reads 0
    {4'd4, 1'b0, 8'h14, 32'h0,        32'h0}      // R4 unused offset
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int s0, o0, q0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", irq, 0);
    chk("R1 obl_req", obl_req, 0);
    chk("R1 sys_rst_req", sys_rst_req, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(1'b0, AW'(VEC[i][71:64]), VEC[i][63:32]);
      else begin
        @(negedge clk); rd(AW'(VEC[i][71:64]), r);
        chk($sformatf("R%0d row %0d", VEC[i][76:73], i), r, VEC[i][31:0]);
      end
    end

    // R12 reload pulse
    @(negedge clk); o0 = obl_n; q0 = rst_n_cnt;
    wr(1'b0, 12'h10, 32'h2000);
    repeat (2) @(negedge clk);
    chk("R12 obl count", obl_n - o0, 1);
    chk("R12 sys reset count", rst_n_cnt - q0, 1);

    // R6 program a blank halfword
    wr(1'b0, 12'h10, 32'h1);
    s0 = strobes;
    wr(1'b1, 12'h004, 32'h1234);
    rd(12'h0C, r);
    chk("R6 busy after start", r[0], 1);
    wait_idle();
    rd(12'h0C, r);
    chk("R6 status after done", r, 32'h20);
    chk("R6 cell written", mem[2], 16'h1234);
    chk("R11 irq eop disabled", irq, 0);
    wr(1'b0, 12'h10, 32'h1001);
    @(negedge clk);
    chk("R11 irq eop enabled", irq, 1);
    wr(1'b0, 12'h0C, 32'h0);
    rd(12'h0C, r);
    chk("R10 write 0 keeps eop", r, 32'h20);
    wr(1'b0, 12'h0C, 32'h20);
    rd(12'h0C, r);
    chk("R10 eop cleared", r, 32'h0);
    chk("R11 irq drops", irq, 0);

    // R8 write during busy ignored
    wr(1'b1, 12'h006, 32'hAAAA);
    wr(1'b1, 12'h008, 32'h5555);
    wait_idle();
    chk("R8 first cell", mem[3], 16'hAAAA);
    chk("R8 second cell untouched", mem[4], 16'hFFFF);
    wr(1'b0, 12'h0C, 32'h20);

    // R7 non-blank target
    s0 = strobes;
    wr(1'b1, 12'h00A, 32'h1111);
    rd(12'h0C, r);
    chk("R7 busy in check", r, 32'h1);
    @(negedge clk); rd(12'h0C, r);
    chk("R7 error flagged busy low", r, 32'h4);
    repeat (5) @(negedge clk);
    chk("R7 no strobe", strobes - s0, 0);
    chk("R7 cell kept", mem[5], 16'h0000);
    chk("R11 irq err disabled", irq, 0);
    wr(1'b0, 12'h10, 32'h0401);
    @(negedge clk);
    chk("R11 irq err enabled", irq, 1);
    wr(1'b0, 12'h0C, 32'h4);
    rd(12'h0C, r);
    chk("R10 pgerr cleared", r, 32'h0);

    // R13 PG clear
    wr(1'b0, 12'h10, 32'h0);
    s0 = strobes;
    wr(1'b1, 12'h00C, 32'h7777);
    rd(12'h0C, r);
    chk("R13 not busy", r, 32'h0);
    repeat (6) @(negedge clk);
    chk("R13 no strobe", strobes - s0, 0);
    chk("R13 cell untouched", mem[6], 16'hFFFF);

    // R9 and R2 relock
    wr(1'b0, 12'h10, 32'h81);
    @(negedge clk); rd(12'h10, r);
    chk("R2 relock", r, 32'h81);
    wr(1'b1, 12'h00E, 32'h3333);
    rd(12'h0C, r);
    chk("R9 write-protect flag", r, 32'h10);
    repeat (6) @(negedge clk);
    chk("R9 cell untouched", mem[7], 16'hFFFF);
    wr(1'b0, 12'h0C, 32'h10);
    rd(12'h0C, r);
    chk("R10 wrprt cleared", r, 32'h0);

    // R2 wrong key jams lock
    wr(1'b0, 12'h04, 32'h1);
    wr(1'b0, 12'h04, KA);
    wr(1'b0, 12'h04, KB);
    @(negedge clk); rd(12'h10, r);
    chk("R2 jammed lock", r, 32'h81);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule